// File: doc/BRIEF.md
# Indirect Test-Port Word Access Sequencer

This block moves one 64-bit word to or from an instruction memory that the normal load path cannot reach. The only path into that memory is an indirect register set: a command register and two 32-bit data registers. The block accepts a request made of a byte address, a read/write flag and 64 bits of write data. It builds the command word by spreading the address bits over fixed, non-contiguous command fields. It then steps through the register accesses in the required order and reports the result with a one-cycle done pulse.

Each sequence ends by returning the command register to zero, so no write command is ever left pending. A cycle of settling separates every pair of dependent register updates. Busy stays high for the whole sequence, and requests made during that time are ignored, so the data-register contents always stay paired with their command. Requests that fall outside the instruction region finish at once: a write makes no register access at all, and a read returns zero.

Top module: `imem_tport_seq`

## Requirements
- R1: The command carries address bits 14 and 10:3 at the same positions. Address bit 15 appears at command bit 38 and also at bit 23. Address bit 11 appears at bit 26, and address bits 13:12 appear at bits 17:16.
- R2: Every issued command has bit 24 (instruction access) and bit 2 (data array) set. Bit 1 is 1 for a write and 0 for a read. Bits 0 and 39 are always 0.
- R3: Address bits 2:0 have no effect. Requests that differ only in those bits reach the same 64-bit word.
- R4: For a write, the data registers are loaded at least one cycle before the command appears. The low 32 bits go to data register 0 (`tp_data_out[31:0]`) and the high 32 bits go to data register 1 (`tp_data_out[63:32]`).
- R5: For a read, the command is issued first and the array word is then captured into the data registers. `rd_data` returns data register 0 as bits 31:0 and data register 1 as bits 63:32.
- R6: The command register returns to zero before `done` is raised, and it is zero whenever `busy` is low.
- R7: A write whose address is at or above `REGION_END` issues no command and leaves the array unchanged.
- R8: A read whose address is at or above `REGION_END` issues no command. It raises `done` after the accepting edge, with `rd_data` equal to zero.
- R9: A request is accepted only while `busy` is low. A request made while busy causes no access and no extra `done`.
- R10: Counting the accepting edge as the first, `done` is high after the 4th edge for an in-range read and after the 6th edge for an in-range write.
- R11: After reset, `busy` and `done` are 0, `tp_cmd` is 0 and `rd_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when busy is low |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address within the instruction region |
| req_wdata | input | DATA_W | Word to write |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | DATA_W | Result of the last read |
| tp_cmd | output | CMD_W | Command register contents |
| tp_data_out | output | DATA_W | Data registers {reg1, reg0} |
| tp_rd_data | input | DATA_W | Word returned by the array while a read command is held |

## Verification
The bench uses the default parameters: a 32-bit address, a 64-bit word, a 40-bit command and a region end of 0x10000. With these values every scrambled address bit, bits 15 down to 3, can be driven and decoded back. Addresses just above the region end also stay reachable, which covers the drop-write and zero-read paths. Random traffic spreads over the whole region and a margin beyond it. Directed cases cover sub-word offsets, the last word of the region, the first address past the end, and a request made while busy.

// File: rtl/imem_tport_pkg.sv
// Package: shared sizes and the sequencer state type.
// Assumes the data path is a whole number of 32-bit halves.
package imem_tport_pkg;
    localparam int HALF_W = 32;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_SYNC_A,
        ST_ISSUE,
        ST_SYNC_B,
        ST_CLEAR
    } seq_state_e;
endpackage

// File: rtl/imem_tport_cmd_build.sv
// Command builder: spreads a byte address over the command fields and adds the fixed flags.
// Assumes ADDR_W >= 16 and CMD_W >= 39; address bits 2:0 are not used.
module imem_tport_cmd_build #(
    parameter int ADDR_W = 32,
    parameter int CMD_W  = 40
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              is_write,
    output logic [CMD_W-1:0]  cmd
);
    localparam int BANK_BIT  = 38;
    localparam int HI15_BIT  = 23;
    localparam int A11_BIT   = 26;
    localparam int A13_LO    = 16;
    localparam int INSTR_BIT = 24;
    localparam int ARRAY_BIT = 2;
    localparam int OP_BIT    = 1;

    // Place each address field and flag in its command position.
    always_comb begin
        cmd                  = '0;
        cmd[14]              = addr[14];
        cmd[10:3]            = addr[10:3];
        cmd[BANK_BIT]        = addr[15];
        cmd[HI15_BIT]        = addr[15];
        cmd[A11_BIT]         = addr[11];
        cmd[A13_LO+1:A13_LO] = addr[13:12];
        cmd[INSTR_BIT]       = 1'b1;
        cmd[ARRAY_BIT]       = 1'b1;
        cmd[OP_BIT]          = is_write;
    end
endmodule

// File: rtl/imem_tport_regs.sv
// Register model of the test port: one command register and DATA_W/32 data registers.
// Data registers load from the request or capture the array word; they never do both in one cycle.
module imem_tport_regs
    import imem_tport_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int CMD_W  = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_set,
    input  logic              cmd_clr,
    input  logic [CMD_W-1:0]  cmd_in,
    input  logic              data_ld,
    input  logic              data_cap,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] arr_rdata,
    output logic [CMD_W-1:0]  cmd_q,
    output logic [DATA_W-1:0] data_q
);
    localparam int HALVES = DATA_W / HALF_W;

    // Command register: written on issue, returned to zero on clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       cmd_q <= '0;
        else if (cmd_clr) cmd_q <= '0;
        else if (cmd_set) cmd_q <= cmd_in;
    end

    for (genvar g = 0; g < HALVES; g++) begin : g_half
        // One 32-bit data register: load from the request or capture the array.
        always_ff @(posedge clk) begin
            if (!rst_n)
                data_q[g*HALF_W +: HALF_W] <= '0;
            else if (data_ld)
                data_q[g*HALF_W +: HALF_W] <= wdata[g*HALF_W +: HALF_W];
            else if (data_cap)
                data_q[g*HALF_W +: HALF_W] <= arr_rdata[g*HALF_W +: HALF_W];
        end
    end
endmodule

// File: rtl/imem_tport_fsm.sv
// Sequencer: takes a request when idle, orders the data and command accesses with
// a settling cycle between them, clears the command and pulses done.
// Assumes the array answers a read command within one cycle.
module imem_tport_fsm
    import imem_tport_pkg::*;
#(
    parameter int          ADDR_W     = 32,
    parameter int          DATA_W     = 64,
    parameter logic [31:0] REGION_END = 32'h0001_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] data_q,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] addr_q,
    output logic              wr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic              cmd_set,
    output logic              cmd_clr,
    output logic              data_ld,
    output logic              data_cap
);
    seq_state_e state;
    logic       accept;
    logic       in_range;

    assign accept   = req_valid && (state == ST_IDLE);
    assign in_range = ({{32{1'b0}}, req_addr} < {{ADDR_W{1'b0}}, REGION_END});
    assign busy     = (state != ST_IDLE);
    assign data_ld  = (state == ST_LOAD);
    assign cmd_set  = (state == ST_ISSUE);
    assign data_cap = (state == ST_SYNC_B) && !wr_q;
    assign cmd_clr  = (state == ST_CLEAR);

    // Step through the access sequence for the latched request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            case (state)
                ST_IDLE:   if (accept && in_range) state <= req_write ? ST_LOAD : ST_ISSUE;
                ST_LOAD:   state <= ST_SYNC_A;
                ST_SYNC_A: state <= ST_ISSUE;
                ST_ISSUE:  state <= ST_SYNC_B;
                ST_SYNC_B: state <= ST_CLEAR;
                default:   state <= ST_IDLE;
            endcase
        end
    end

    // Hold the accepted request for the length of the sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wr_q    <= 1'b0;
            wdata_q <= '0;
        end else if (accept) begin
            addr_q  <= req_addr;
            wr_q    <= req_write;
            wdata_q <= req_wdata;
        end
    end

    // Raise done and update the read result when a request finishes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done    <= 1'b0;
            rd_data <= '0;
        end else begin
            done <= 1'b0;
            if (accept && !in_range) begin
                done <= 1'b1;
                if (!req_write) rd_data <= '0;
            end else if (state == ST_CLEAR) begin
                done <= 1'b1;
                if (!wr_q) rd_data <= data_q;
            end
        end
    end
endmodule

// File: rtl/imem_tport_seq.sv
// Top: indirect test-port word access sequencer. Joins the command builder,
// the register model and the sequencer; the array sits outside on tp_* ports.
module imem_tport_seq
    import imem_tport_pkg::*;
#(
    parameter int          ADDR_W     = 32,
    parameter int          DATA_W     = 64,
    parameter int          CMD_W      = 40,
    parameter logic [31:0] REGION_END = 32'h0001_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic [CMD_W-1:0]  tp_cmd,
    output logic [DATA_W-1:0] tp_data_out,
    input  logic [DATA_W-1:0] tp_rd_data
);
    logic [ADDR_W-1:0] addr_q;
    logic              wr_q;
    logic [DATA_W-1:0] wdata_q;
    logic              cmd_set, cmd_clr, data_ld, data_cap;
    logic [CMD_W-1:0]  cmd_word;

    imem_tport_fsm #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REGION_END(REGION_END)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .data_q(tp_data_out),
        .busy(busy), .done(done), .rd_data(rd_data),
        .addr_q(addr_q), .wr_q(wr_q), .wdata_q(wdata_q),
        .cmd_set(cmd_set), .cmd_clr(cmd_clr),
        .data_ld(data_ld), .data_cap(data_cap)
    );

    imem_tport_cmd_build #(.ADDR_W(ADDR_W), .CMD_W(CMD_W)) u_cmd (
        .addr(addr_q), .is_write(wr_q), .cmd(cmd_word)
    );

    imem_tport_regs #(.DATA_W(DATA_W), .CMD_W(CMD_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .cmd_set(cmd_set), .cmd_clr(cmd_clr), .cmd_in(cmd_word),
        .data_ld(data_ld), .data_cap(data_cap),
        .wdata(wdata_q), .arr_rdata(tp_rd_data),
        .cmd_q(tp_cmd), .data_q(tp_data_out)
    );
endmodule

// File: rtl/imem_tport_seq_chk.sv
// Checker for the sequencer's port-level ordering rules; bound to the top.
module imem_tport_seq_chk #(
    parameter int DATA_W = 64,
    parameter int CMD_W  = 40
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              busy,
    input logic              done,
    input logic [CMD_W-1:0]  tp_cmd,
    input logic [DATA_W-1:0] tp_data_out
);
    // R6
    cmd_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (tp_cmd == '0));

    // R6
    done_cmd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (tp_cmd == '0));

    // R2
    cmd_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tp_cmd != '0) |-> (tp_cmd[24] && tp_cmd[2] && !tp_cmd[0] && !tp_cmd[CMD_W-1]));

    // R4
    wr_data_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tp_cmd[1] && $past(tp_cmd) == '0) |-> $stable(tp_data_out));

    // R9
    accept_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req_valid));

    // R6
    cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(tp_cmd) != '0 && tp_cmd != '0) |-> $stable(tp_cmd));
endmodule

bind imem_tport_seq imem_tport_seq_chk #(.DATA_W(DATA_W), .CMD_W(CMD_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .busy(busy), .done(done),
    .tp_cmd(tp_cmd), .tp_data_out(tp_data_out)
);

// File: tb/imem_tport_seq_tb_top.sv
module imem_tport_seq_tb_top;
    localparam logic [31:0] END_ADDR = 32'h0001_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [31:0] req_addr = '0;
    logic [63:0] req_wdata = '0;
    logic        busy, done;
    logic [63:0] rd_data;
    logic [39:0] tp_cmd;
    logic [63:0] tp_data_out;
    logic [63:0] tp_rd_data;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    logic [63:0] arr [int];   // array behind the port, indexed by decoded command
    logic [63:0] ref_m [int]; // expected contents, indexed by address word

    always #4 clk = ~clk;

    imem_tport_seq dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
        .rd_data(rd_data), .tp_cmd(tp_cmd), .tp_data_out(tp_data_out),
        .tp_rd_data(tp_rd_data)
    );

    function automatic logic [39:0] exp_cmd(input logic [31:0] a, input logic w);
        logic [39:0] c = '0;
        c[38] = a[15]; c[26] = a[11]; c[24] = 1'b1; c[23] = a[15];
        c[17] = a[13]; c[16] = a[12]; c[14] = a[14];
        for (int i = 3; i <= 10; i++) c[i] = a[i];
        c[2] = 1'b1; c[1] = w;
        return c;
    endfunction

    function automatic int cmd_index(input logic [39:0] c);
        return int'({c[38], c[14], c[17:16], c[26], c[10:3]});
    endfunction

    function automatic logic [63:0] arr_get(input int idx);
        if (arr.exists(idx)) return arr[idx];
        return 64'h0;
    endfunction

    function automatic logic [63:0] ref_get(input logic [31:0] a);
        if (a >= END_ADDR) return 64'h0;
        if (ref_m.exists(int'(a[15:3]))) return ref_m[int'(a[15:3])];
        return 64'h0;
    endfunction

    always_comb begin
        if (tp_cmd[24] && !tp_cmd[1]) tp_rd_data = arr_get(cmd_index(tp_cmd));
        else                          tp_rd_data = 64'hBAD0_BAD0_BAD0_BAD0;
    end

    always @(posedge clk) begin
        if (tp_cmd[24] && tp_cmd[1]) arr[cmd_index(tp_cmd)] = tp_data_out;
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    // One request: drive before an edge, then count edges to done.
    task automatic do_op(input logic w, input logic [31:0] a, input logic [63:0] d,
                         input bit poke_busy, output logic [63:0] r);
        int lat = 1;
        bit in_rng = (a < END_ADDR);
        bit cmd_seen = 0;
        bit data_ok = 1;
        logic [39:0] ec = exp_cmd(a, w);
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        while (!done && lat < 40) begin
            if (tp_cmd != '0) begin
                cmd_seen = 1;
                if (tp_cmd != ec)
                    check(0, "R1/R2 cmd word", {24'h0, tp_cmd}, {24'h0, ec});
                if (w && tp_data_out != d) data_ok = 0;
            end
            if (poke_busy && lat == 2) begin
                req_valid = 1'b1; req_write = 1'b1;
                req_addr = a ^ 32'h0000_0100; req_wdata = ~d;
            end else begin
                req_valid = 1'b0;
            end
            @(posedge clk);
            @(negedge clk);
            lat++;
        end
        req_valid = 1'b0;
        r = rd_data;
        if (!in_rng) begin
            check(lat == 1, "R7/R8 immediate done", 64'(lat), 64'd1);
            check(!cmd_seen, "R7/R8 no command issued", {63'h0, cmd_seen}, 64'h0);
        end else begin
            check(lat == (w ? 6 : 4), "R10 latency", 64'(lat), w ? 64'd6 : 64'd4);
            check(cmd_seen, "R1 command issued", {63'h0, cmd_seen}, 64'h1);
            if (w) check(data_ok, "R4 data regs hold write word", tp_data_out, d);
        end
        check(tp_cmd == '0, "R6 command cleared at done", {24'h0, tp_cmd}, 64'h0);
        @(negedge clk);
        check(!done, "R9 single done pulse", {63'h0, done}, 64'h0);
    endtask

    task automatic wr(input logic [31:0] a, input logic [63:0] d);
        logic [63:0] r;
        do_op(1'b1, a, d, 0, r);
        if (a < END_ADDR) ref_m[int'(a[15:3])] = d;
    endtask

    task automatic rd_chk(input logic [31:0] a, input string req);
        logic [63:0] r;
        logic [63:0] e = ref_get(a);
        do_op(1'b0, a, 64'h0, 0, r);
        check(r == e, req, r, e);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check(0, "watchdog", 64'h0, 64'h1);
        finish_run();
    end

    initial begin
        logic [63:0] r;
        void'($urandom(32'd2718));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11 reset state
        check(!busy && !done, "R11 busy/done after reset", {62'h0, busy, done}, 64'h0);
        check(tp_cmd == '0, "R11 cmd after reset", {24'h0, tp_cmd}, 64'h0);
        check(rd_data == '0, "R11 rd_data after reset", rd_data, 64'h0);
        rst_n = 1'b1;

        // R5 half order via a known word
        wr(32'h0000_0040, 64'h1122_3344_5566_7788);
        rd_chk(32'h0000_0040, "R5 read halves");
        // R3 low address bits ignored
        wr(32'h0000_8A35, 64'hCAFE_0000_0000_BEEF);
        rd_chk(32'h0000_8A30, "R3 offset write seen aligned");
        rd_chk(32'h0000_8A37, "R3 offset read");
        // R1 every scrambled bit on its own
        for (int b = 3; b <= 15; b++) begin
            wr(32'h1 << b, 64'h0100_0000_0000_0000 | 64'(b));
        end
        for (int b = 3; b <= 15; b++) rd_chk(32'h1 << b, "R1 single-bit address");
        // R7 out-of-range write dropped; last word and boundary
        wr(32'h0000_FFF8, 64'h5A5A_5A5A_A5A5_A5A5);
        do_op(1'b1, END_ADDR, 64'hFFFF_FFFF_FFFF_FFFF, 0, r);
        rd_chk(32'h0000_FFF8, "R7 last word unchanged");
        rd_chk(32'h0000_0000, "R7 word 0 untouched by wrap");
        // R8 out-of-range read returns zero
        do_op(1'b0, END_ADDR + 32'h10, 64'h0, 0, r);
        check(r == 64'h0, "R8 zero read beyond region", r, 64'h0);
        // R9 request while busy is ignored
        do_op(1'b0, 32'h0000_0040, 64'h0123_4567_89AB_CDEF, 1, r);
        rd_chk(32'h0000_0140, "R9 busy request dropped");

        // random mix
        for (int n = 0; n < 300; n++) begin
            logic [31:0] a = $urandom() % 32'h0001_2000;
            logic [63:0] d = {$urandom(), $urandom()};
            if ($urandom() % 2) wr(a, d);
            else rd_chk(a, "R5 random read");
        end
        finish_run();
    end
endmodule